// File: doc/BRIEF.md
# Serial Configuration Master with Daisy-Chain Relay

This block is the configuration port of the first device in a chain of programmable devices. It produces the configuration clock, reads one bit per clock from an external serial memory, and keeps the bits meant for its own device. Every other bit is passed on to the next device in the chain. The memory moves to its next bit on each rising edge of the configuration clock. The block takes that bit on the following rising edge.

A frame starts with a marker field of `MK_W` bits, followed by a length field of `LEN_W` bits sent most significant bit first. The length gives the total number of configuration clocks to issue. The `OWN_BITS` bits after the preamble go to the local device on a strobed output. The preamble and all bits after the local ones are repeated on the relay output. The relay output changes only on falling edges of the configuration clock, 1.5 clock periods after the bit was sampled. A downstream device can therefore capture each bit on its next rising edge.

An active-low loading strobe stays low during the whole load and can enable the memory. A done flag can enable the memory instead. In early mode the done flag rises a set number of clocks before the load ends.

Top module: `cfg_serial_master`

## Requirements
- R1: After reset `cclk` is low. While loading, it is high for `HALF_DIV` system clocks and low for `HALF_DIV` system clocks. Its first rising edge comes `HALF_DIV` system clocks after reset is released.
- R2: `din` is sampled at the system edge where `cclk` rises. The memory presents bit k after rising edge k-1, so the k-th rising edge (counted from 0) captures frame bit k.
- R3: Frame bits 0..`MK_W`-1 are the marker and are not checked. Bits `MK_W`..`MK_W+LEN_W`-1 are the length, sent MSB first. The number of rising edges issued is N = max(length, `MK_W+LEN_W`).
- R4: Frame bits `MK_W+LEN_W` through `MK_W+LEN_W+OWN_BITS`-1 (only those below N) appear in order on `cfg_bit`. Each comes with a one-cycle `cfg_valid` pulse in the cycle where `cclk` rises to sample that bit. No other bit raises `cfg_valid`.
- R5: `dout` changes only in the system cycle where `cclk` falls.
- R6: At the falling edge after rising edge k+1, `dout` shows frame bit k if that bit is a preamble bit or lies beyond the local bits. Otherwise `dout` shows 1. `dout` is 1 at the fall after rising edge 0.
- R7: `ldc_n` is low from reset until the falling edge that follows rising edge N, where it goes high. After that it stays high and `cclk` stays low until the next reset.
- R8: With `early_mode` low, `done` rises in the same cycle as `ldc_n`.
- R9: With `early_mode` high, `done` rises at the first rising edge whose running count c satisfies both c ≥ `MK_W+LEN_W` and c + `EARLY_GAP` ≥ length. It then stays high until reset.
- R10: A synchronous reset in the middle of a frame returns `cclk`, `ldc_n`, `done`, `cfg_valid` and `dout` to their reset values. The next frame is read from bit 0.
- R11: `dout` idles at 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset that restarts loading |
| early_mode | input | 1 | Selects early assertion of `done` |
| din | input | 1 | Serial data from the external memory |
| cclk | output | 1 | Configuration clock to the memory and the chain |
| dout | output | 1 | Relay data to the next device in the chain |
| ldc_n | output | 1 | Low while loading; usable as memory enable |
| done | output | 1 | Configuration complete flag; usable as memory enable |
| cfg_valid | output | 1 | Strobe for a bit kept by this device |
| cfg_bit | output | 1 | Bit kept by this device |

## Verification
The bench builds the block with `HALF_DIV`=2, `MK_W`=4, `LEN_W`=8, `OWN_BITS`=6 and `EARLY_GAP`=3, which makes the preamble 12 bits long. An 8-bit length field keeps a full-length frame of 255 clocks short enough to run many times. With these values the bench can reach a length below the preamble, a frame that ends exactly after the local bits, and a frame where early done fires at the end of the preamble. A 4-cycle configuration clock makes the 1.5-period relay offset and the half-period timing visible at the granularity of single system cycles.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ROLE_MARK = 2'd0,
        ROLE_LEN  = 2'd1,
        ROLE_OWN  = 2'd2,
        ROLE_FWD  = 2'd3
    } role_e;

    typedef struct packed {
        logic data;
        logic fwd;
    } relay_slot_t;

    localparam relay_slot_t SLOT_IDLE = '{data: 1'b1, fwd: 1'b0};

    // Two rising edges of storage give the 1.5-period relay delay with a fall update
    localparam int RELAY_DEPTH = 2;

    function automatic role_e role_of(input int unsigned idx,
                                      input int unsigned mk_w,
                                      input int unsigned len_w,
                                      input int unsigned own_n);
        if (idx < mk_w)                return ROLE_MARK;
        if (idx < mk_w + len_w)        return ROLE_LEN;
        if (idx < mk_w + len_w + own_n) return ROLE_OWN;
        return ROLE_FWD;
    endfunction

    function automatic logic role_forwards(input role_e r);
        return r != ROLE_OWN;
    endfunction

endpackage

// File: rtl/cfgm_clkgen.sv
module cfgm_clkgen #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic cclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div_q;
    logic          cclk_q;
    logic          tick;

    assign tick = (div_q == DW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            cclk_q <= 1'b0;
        end else if (run) begin
            if (tick) begin
                div_q  <= '0;
                cclk_q <= ~cclk_q;
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign rise_evt = run & tick & ~cclk_q;
    assign fall_evt = run & tick &  cclk_q;
    assign cclk     = cclk_q;

    // R1
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (cclk_q != $past(cclk_q)) |-> ($past(div_q) == DW'(HALF_DIV - 1)));

    // R7
    stopped_clock_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cclk_q));

endmodule

// File: rtl/cfgm_framer.sv
module cfgm_framer
    import cfgm_pkg::*;
#(
    parameter int MK_W      = 4,
    parameter int LEN_W     = 12,
    parameter int OWN_BITS  = 8,
    parameter int EARLY_GAP = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        early_mode,
    input  logic        din,
    input  logic        rise_evt,
    input  logic        fall_evt,
    output logic        run,
    output logic        ldc_n,
    output logic        done,
    output logic        cfg_valid,
    output logic        cfg_bit,
    output relay_slot_t slot
);
    localparam int PRE_W  = MK_W + LEN_W;
    localparam int PRE_CW = $clog2(PRE_W + 1);
    localparam int CNT_W  = ((PRE_CW > LEN_W) ? PRE_CW : LEN_W) + 1;

    phase_e           ph_q;
    logic [CNT_W-1:0] rcnt_q;
    logic [CNT_W-1:0] rcnt_nx;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_nx;
    role_e            role_now;
    logic             pre_done;
    logic             last_rise;
    logic             early_hit;
    logic             ldc_n_q;
    logic             done_q;
    logic             cfg_valid_q;
    logic             cfg_bit_q;

    assign role_now  = role_of(32'(rcnt_q), MK_W, LEN_W, OWN_BITS);
    assign rcnt_nx   = rcnt_q + CNT_W'(1);
    assign len_nx    = (role_now == ROLE_LEN) ? {len_q[LEN_W-2:0], din} : len_q;
    assign pre_done  = (rcnt_nx >= CNT_W'(PRE_W));
    assign last_rise = pre_done && (rcnt_nx >= CNT_W'(len_nx));
    assign early_hit = pre_done && ((rcnt_nx + CNT_W'(EARLY_GAP)) >= CNT_W'(len_nx));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q        <= PH_LOAD;
            rcnt_q      <= '0;
            len_q       <= '0;
            ldc_n_q     <= 1'b0;
            done_q      <= 1'b0;
            cfg_valid_q <= 1'b0;
            cfg_bit_q   <= 1'b0;
        end else begin
            cfg_valid_q <= 1'b0;
            unique case (ph_q)
                PH_LOAD: begin
                    if (rise_evt) begin
                        rcnt_q <= rcnt_nx;
                        len_q  <= len_nx;
                        if (role_now == ROLE_OWN) begin
                            cfg_valid_q <= 1'b1;
                            cfg_bit_q   <= din;
                        end
                        if (early_mode && early_hit) done_q <= 1'b1;
                        if (last_rise) ph_q <= PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    if (fall_evt) begin
                        ph_q    <= PH_FINISH;
                        ldc_n_q <= 1'b1;
                        done_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign run       = (ph_q != PH_FINISH);
    assign ldc_n     = ldc_n_q;
    assign done      = done_q;
    assign cfg_valid = cfg_valid_q;
    assign cfg_bit   = cfg_bit_q;
    assign slot      = '{data: din, fwd: role_forwards(role_now)};

    // R7
    ldc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ldc_n_q |=> ldc_n_q);

    // R8
    done_with_ldc_chk: assert property (@(posedge clk) disable iff (rst)
        ldc_n_q |-> done_q);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    // R4
    own_while_loading_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid_q |-> !ldc_n_q);

endmodule

// File: rtl/cfgm_relay.sv
module cfgm_relay
    import cfgm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  relay_slot_t slot_in,
    output logic        dout
);
    relay_slot_t stage_q [RELAY_DEPTH];
    logic        dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RELAY_DEPTH; i++) stage_q[i] <= SLOT_IDLE;
            dout_q <= 1'b1;
        end else begin
            if (rise_evt) begin
                stage_q[0] <= slot_in;
                for (int i = 1; i < RELAY_DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
            if (fall_evt) begin
                dout_q <= stage_q[RELAY_DEPTH-1].fwd ? stage_q[RELAY_DEPTH-1].data : 1'b1;
            end
        end
    end

    assign dout = dout_q;

    // R5
    relay_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_q != $past(dout_q)) |-> $past(fall_evt));

endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
    import cfgm_pkg::*;
#(
    parameter int HALF_DIV  = 3,
    parameter int MK_W      = 4,
    parameter int LEN_W     = 12,
    parameter int OWN_BITS  = 8,
    parameter int EARLY_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic early_mode,
    input  logic din,
    output logic cclk,
    output logic dout,
    output logic ldc_n,
    output logic done,
    output logic cfg_valid,
    output logic cfg_bit
);
    logic        run;
    logic        rise_evt;
    logic        fall_evt;
    relay_slot_t slot;

    cfgm_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cclk     (cclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    cfgm_framer #(
        .MK_W      (MK_W),
        .LEN_W     (LEN_W),
        .OWN_BITS  (OWN_BITS),
        .EARLY_GAP (EARLY_GAP)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .early_mode (early_mode),
        .din        (din),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt),
        .run        (run),
        .ldc_n      (ldc_n),
        .done       (done),
        .cfg_valid  (cfg_valid),
        .cfg_bit    (cfg_bit),
        .slot       (slot)
    );

    cfgm_relay u_relay (
        .clk      (clk),
        .rst      (rst),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .slot_in  (slot),
        .dout     (dout)
    );

    // R5
    dout_on_cclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> ($past(cclk) && !cclk));

    // R7
    cclk_parked_chk: assert property (@(posedge clk) disable iff (rst)
        ldc_n |-> !cclk);

endmodule

// File: tb/tb_cfg_serial_master.sv
`timescale 1ns/1ps
module tb_cfg_serial_master;
    localparam int HALF_DIV  = 2;
    localparam int MK_W      = 4;
    localparam int LEN_W     = 8;
    localparam int OWN_BITS  = 6;
    localparam int EARLY_GAP = 3;
    localparam int PRE_W     = MK_W + LEN_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic early_mode = 1'b0;
    logic din = 1'b0;
    logic cclk, dout, ldc_n, done, cfg_valid, cfg_bit;

    int checks = 0;
    int failures = 0;
    bit mem [0:511];

    always #4 clk = ~clk;

    cfg_serial_master #(
        .HALF_DIV(HALF_DIV), .MK_W(MK_W), .LEN_W(LEN_W),
        .OWN_BITS(OWN_BITS), .EARLY_GAP(EARLY_GAP)
    ) dut (
        .clk(clk), .rst(rst), .early_mode(early_mode), .din(din),
        .cclk(cclk), .dout(dout), .ldc_n(ldc_n), .done(done),
        .cfg_valid(cfg_valid), .cfg_bit(cfg_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit fwd_idx(input int idx);
        return (idx < PRE_W) || (idx >= PRE_W + OWN_BITS);
    endfunction

    function automatic int total_rises(input int len);
        return (len > PRE_W) ? len : PRE_W;
    endfunction

    function automatic int own_count(input int n);
        int s;
        s = n - PRE_W;
        if (s < 0) s = 0;
        return (s > OWN_BITS) ? OWN_BITS : s;
    endfunction

    task automatic run_frame(input int len, input bit early, input int abort_at);
        int n, rises, cyc, hi_run, lo_run, cfg_idx, expv;
        bit prev_cclk, prev_dout, fired, finished, fall_now, rise_now;
        logic [LEN_W-1:0] lv;
        lv = LEN_W'(len);
        for (int i = 0; i < 512; i++) mem[i] = 1'($urandom_range(0, 1));
        for (int b = 0; b < LEN_W; b++) mem[MK_W + b] = lv[LEN_W-1-b];
        n = total_rises(len);
        @(negedge clk);
        rst = 1'b1;
        early_mode = early;
        din = mem[0];
        @(negedge clk);
        @(negedge clk);
        // R10 R11 R1: reset values
        chk(cclk == 1'b0, "R1 reset cclk", int'(cclk), 0);
        chk(dout == 1'b1, "R11 reset dout", int'(dout), 1);
        chk(ldc_n == 1'b0 && done == 1'b0 && cfg_valid == 1'b0,
            "R10 reset strobes", int'({ldc_n, done, cfg_valid}), 0);
        rst = 1'b0;
        rises = 0; cyc = 0; hi_run = 0; lo_run = 0; cfg_idx = 0;
        prev_cclk = 1'b0; prev_dout = dout; fired = 1'b0; finished = 1'b0;
        while (!finished) begin
            @(negedge clk);
            cyc++;
            rise_now = cclk && !prev_cclk;
            fall_now = !cclk && prev_cclk;
            if (rise_now) begin
                rises++;
                if (rises == 1) chk(cyc == HALF_DIV, "R1 first rise", cyc, HALF_DIV);
                else            chk(lo_run == HALF_DIV, "R1 low time", lo_run, HALF_DIV);
                hi_run = 1;
                din = mem[rises];
                if (early && rises >= PRE_W && rises + EARLY_GAP >= len) fired = 1'b1;
            end else if (fall_now) begin
                chk(hi_run == HALF_DIV, "R1 high time", hi_run, HALF_DIV);
                lo_run = 1;
                expv = (rises >= 2 && fwd_idx(rises - 2)) ? int'(mem[rises - 2]) : 1;
                chk(int'(dout) == expv, "R6 relay bit", int'(dout), expv);
                if (rises == n) begin
                    chk(ldc_n == 1'b1, "R7 ldc_n high at end", int'(ldc_n), 1);
                    chk(done == 1'b1, "R8 done at end", int'(done), 1);
                    finished = 1'b1;
                end else begin
                    chk(ldc_n == 1'b0, "R7 ldc_n low while loading", int'(ldc_n), 0);
                end
            end else begin
                if (cclk) hi_run++; else lo_run++;
                chk(dout == prev_dout, "R5 dout stable off fall", int'(dout), int'(prev_dout));
            end
            if (!finished)
                chk(done == fired, early ? "R9 early done" : "R8 done timing", int'(done), int'(fired));
            if (cfg_valid) begin
                chk(rise_now, "R4 cfg_valid with rise", int'(rise_now), 1);
                chk(rises - 1 == PRE_W + cfg_idx, "R2 own bit index", rises - 1, PRE_W + cfg_idx);
                chk(cfg_bit == mem[PRE_W + cfg_idx], "R4 cfg_bit value",
                    int'(cfg_bit), int'(mem[PRE_W + cfg_idx]));
                cfg_idx++;
            end
            prev_cclk = cclk;
            prev_dout = dout;
            if (abort_at > 0 && rises == abort_at) return;
            if (cyc > 20000) begin
                chk(1'b0, "R7 frame timeout", cyc, 20000);
                return;
            end
        end
        chk(rises == n, "R3 rise count", rises, n);
        chk(cfg_idx == own_count(n), "R4 own bit count", cfg_idx, own_count(n));
        for (int w = 0; w < 4 * HALF_DIV; w++) begin
            @(negedge clk);
            chk(cclk == 1'b0 && ldc_n == 1'b1 && done == 1'b1,
                "R7 parked after load", int'({cclk, ldc_n, done}), 3);
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        run_frame(3, 1'b0, 0);                       // R3 length below preamble
        run_frame(3, 1'b1, 0);                       // R9 early fires at preamble end
        run_frame(PRE_W + OWN_BITS, 1'b0, 0);        // R4 no surplus bits
        run_frame(PRE_W + OWN_BITS, 1'b1, 0);
        run_frame(40, 1'b0, 0);                      // R6 surplus forwarding
        run_frame(255, 1'b1, 0);                     // R3 maximum length
        run_frame(90, 1'b1, 30);                     // R10 abort mid-frame
        run_frame(50, 1'b0, 0);                      // R10 clean restart after abort
        for (int f = 0; f < 8; f++)
            run_frame(int'($urandom_range(5, 120)), 1'($urandom_range(0, 1)), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule